// File: doc/BRIEF.md
# Variable-Length Interval Number Load Unpacker

The block turns one packed, self-describing floating-point element in byte-addressed memory into a fixed-layout interval record for a wide-mantissa register file. An element is either a single value or a pair of interval endpoints. Each endpoint opens with two fixed one-bit flags and two size descriptors whose widths come from a configured environment. The size descriptors set the widths of the exponent and fraction fields that follow. The block fetches 64-bit little-endian memory words one at a time and works out how long the element is from the bits it already holds. It requests only the words that the element touches. It then extracts both endpoints and reports the byte address just past the element, so that densely packed arrays can be walked in order.

Each endpoint is delivered as a sign, an exact flag, the raw exponent with its size descriptor, and a fraction left-aligned across up to eight 64-bit chunks (hidden leading one not stored), with a count of the chunks in use. A single value is delivered as an interval with equal endpoints. The environment widths must be legal when a load starts (exponent-size field 1 to ESS_MAX bits, fraction-size field 1 to FSS_MAX bits).

Top module: `unum_load_unpack`

## Requirements
- R1: After reset, busy, done and mem_req are all 0.
- R2: Each memory request is a one-cycle mem_req pulse with a word-aligned mem_addr (low 3 bits zero). The first request is for the word that holds start_addr, and each later request is for the next word up (+8). No new request is issued until mem_rvalid has returned the previous word.
- R3: The element starts at bit 8*(start_addr mod 8) of the first word, and its bits are numbered upward through consecutive words (little-endian). Within an endpoint, in increasing bit order, come: sign (1 bit), exact flag (1 bit), exponent-size-minus-one (cfg_esz_w bits), fraction-size-minus-one (cfg_fsz_w bits), exponent (es = value+1 bits), fraction (fs = value+1 bits). Every field is an unsigned integer with its least significant bit at the lowest position.
- R4: The exponent output is the exponent field zero-extended, and the exp_m1 output is the exponent-size-minus-one field value.
- R5: The fraction output places the most significant fraction bit at bit 511 and continues downward, with all bits below the fraction zero. The len output equals ceil(fs/64), which is always in the range 1 to 8.
- R6: In pair mode, the right endpoint's fields begin at the bit just after the left endpoint's last fraction bit.
- R7: In single mode, every right-endpoint output equals the matching left-endpoint output.
- R8: The number of words requested for a load equals ceil((8*(start_addr mod 8) + total element bits)/64).
- R9: next_addr equals start_addr + ceil(total element bits / 8). Total element bits are one endpoint's length in single mode and both endpoints' lengths in pair mode.
- R10: The mode and environment widths are captured when a load starts. Changes to them, and any start pulse, while busy have no effect on that load.
- R11: done is a one-cycle pulse in the cycle in which busy has just fallen. All result outputs hold their values until the next load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (taken only while idle) |
| start_addr | input | AW | Byte address of the element |
| pair_mode | input | 1 | 1: interval pair, 0: single value |
| cfg_esz_w | input | 3 | Width of the exponent-size field (1..ESS_MAX) |
| cfg_fsz_w | input | 4 | Width of the fraction-size field (1..FSS_MAX) |
| busy | output | 1 | Load in progress |
| done | output | 1 | Result valid pulse |
| mem_req | output | 1 | Word request pulse |
| mem_addr | output | AW | Word-aligned byte address of the request |
| mem_rvalid | input | 1 | Requested word is present on mem_rdata |
| mem_rdata | input | 64 | Returned memory word |
| next_addr | output | AW | Byte address just past the element |
| l_sign | output | 1 | Left endpoint sign |
| l_exact | output | 1 | Left endpoint exact flag |
| l_exp_m1 | output | 4 | Left exponent-size-minus-one |
| l_exp | output | 16 | Left exponent field, zero-extended |
| l_frac | output | 512 | Left fraction, left-aligned |
| l_len | output | 4 | Left chunks in use |
| r_sign | output | 1 | Right endpoint sign |
| r_exact | output | 1 | Right endpoint exact flag |
| r_exp_m1 | output | 4 | Right exponent-size-minus-one |
| r_exp | output | 16 | Right exponent field, zero-extended |
| r_frac | output | 512 | Right fraction, left-aligned |
| r_len | output | 4 | Right chunks in use |

## Verification
The assertions check the request discipline on every cycle: single-cycle pulses, word alignment, and requests only while busy. They also check that the latched mode and widths do not move during a load, that results hold stable while busy, that done never coincides with busy, that the chunk count stays in range with zero chunks beyond it, and that the two endpoints are equal in single mode. Only the bench's sweeps can show that the fields are pulled from the correct bit positions at every start offset and environment. The same holds for stopping after exactly the right number of words, the next-element address, and the right endpoint following the left one directly in pair mode.

// File: rtl/unum_ld_pkg.sv
package unum_ld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EVAL
  } ld_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/unum_ep_decode.sv
// Combinational decoder of one endpoint starting at bit 'pos' of the buffer.
module unum_ep_decode #(
  parameter int ESS_MAX = 4,
  parameter int FSS_MAX = 8,
  parameter int CHUNK_W = 64,
  parameter int CHUNKS  = 8,
  parameter int BUF_W   = 640,
  parameter int POS_W   = 10,
  parameter int ESW_W   = 3,
  parameter int FSW_W   = 4,
  parameter int TOT_W   = 9
) (
  input  logic [BUF_W-1:0]               buf_bits,
  input  logic [POS_W-1:0]               pos,
  input  logic [ESW_W-1:0]               esz_w,
  input  logic [FSW_W-1:0]               fsz_w,
  output logic                           sign,
  output logic                           exact,
  output logic [ESS_MAX-1:0]             exp_m1,
  output logic [(1<<ESS_MAX)-1:0]        exp_val,
  output logic [CHUNKS*CHUNK_W-1:0]      frac,
  output logic [$clog2(CHUNKS+1)-1:0]    len,
  output logic [TOT_W-1:0]               bits
);
  localparam int EXP_MAX = 1 << ESS_MAX;
  localparam int FRAC_W  = CHUNKS * CHUNK_W;
  localparam int LEN_W   = $clog2(CHUNKS + 1);

  // Field of width w starting at bit lo of a window, zero-extended.
  function automatic logic [BUF_W-1:0] pick(input logic [BUF_W-1:0] win,
                                            input int lo, input int w);
    logic [BUF_W-1:0] msk;
    msk = (BUF_W'(1) << w) - BUF_W'(1);
    return (win >> lo) & msk;
  endfunction

  logic [BUF_W-1:0]   win;
  logic [FSS_MAX-1:0] fs_m1;
  logic [FRAC_W-1:0]  frac_raw;
  int ew, fw, es, fs, hdr;

  always_comb begin
    ew       = int'(esz_w);
    fw       = int'(fsz_w);
    win      = buf_bits >> int'(pos);
    sign     = win[0];
    exact    = win[1];
    exp_m1   = ESS_MAX'(pick(win, 2, ew));
    fs_m1    = FSS_MAX'(pick(win, 2 + ew, fw));
    es       = int'(exp_m1) + 1;
    fs       = int'(fs_m1) + 1;
    hdr      = 2 + ew + fw;
    exp_val  = EXP_MAX'(pick(win, hdr, es));
    frac_raw = FRAC_W'(pick(win, hdr + es, fs));
    frac     = frac_raw << (FRAC_W - fs);
    len      = LEN_W'((fs + CHUNK_W - 1) / CHUNK_W);
    bits     = TOT_W'(hdr + es + fs);
  end

endmodule

// File: rtl/unum_word_buffer.sv
// Collects fetched memory words in order into one flat bit buffer.
module unum_word_buffer #(
  parameter int WORD_W    = 64,
  parameter int MAX_WORDS = 10,
  parameter int CNT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        wr_en,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [MAX_WORDS*WORD_W-1:0] buf_bits,
  output logic [CNT_W-1:0]            count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (wr_en) count <= count + CNT_W'(1);
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  word_q <= '0;
      else if (clear)                              word_q <= '0;
      else if (wr_en && (int'(count) == g))        word_q <= wr_data;
    end
    assign buf_bits[g*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/unum_load_unpack.sv
module unum_load_unpack
  import unum_ld_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ESS_MAX = 4,
  parameter int FSS_MAX = 8,
  parameter int CHUNK_W = 64,
  parameter int CHUNKS  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [AW-1:0]                   start_addr,
  input  logic                            pair_mode,
  input  logic [$clog2(ESS_MAX+1)-1:0]    cfg_esz_w,
  input  logic [$clog2(FSS_MAX+1)-1:0]    cfg_fsz_w,
  output logic                            busy,
  output logic                            done,
  output logic                            mem_req,
  output logic [AW-1:0]                   mem_addr,
  input  logic                            mem_rvalid,
  input  logic [CHUNK_W-1:0]              mem_rdata,
  output logic [AW-1:0]                   next_addr,
  output logic                            l_sign,
  output logic                            l_exact,
  output logic [ESS_MAX-1:0]              l_exp_m1,
  output logic [(1<<ESS_MAX)-1:0]         l_exp,
  output logic [CHUNKS*CHUNK_W-1:0]       l_frac,
  output logic [$clog2(CHUNKS+1)-1:0]     l_len,
  output logic                            r_sign,
  output logic                            r_exact,
  output logic [ESS_MAX-1:0]              r_exp_m1,
  output logic [(1<<ESS_MAX)-1:0]         r_exp,
  output logic [CHUNKS*CHUNK_W-1:0]       r_frac,
  output logic [$clog2(CHUNKS+1)-1:0]     r_len
);
  localparam int ESW_W     = $clog2(ESS_MAX + 1);
  localparam int FSW_W     = $clog2(FSS_MAX + 1);
  localparam int EXP_MAX   = 1 << ESS_MAX;
  localparam int FRAC_MAX  = 1 << FSS_MAX;
  localparam int FRAC_W    = CHUNKS * CHUNK_W;
  localparam int LEN_W     = $clog2(CHUNKS + 1);
  localparam int EP_MAX    = 2 + ESS_MAX + FSS_MAX + EXP_MAX + FRAC_MAX;
  localparam int BO_W      = $clog2(CHUNK_W / 8);
  localparam int MAX_WORDS = ceil_div(2 * EP_MAX + CHUNK_W - 8, CHUNK_W);
  localparam int BUF_W     = MAX_WORDS * CHUNK_W;
  localparam int POS_W     = $clog2(BUF_W + 1);
  localparam int TOT_W     = $clog2(EP_MAX + 1);
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  ld_state_t        state;
  logic [AW-1:0]    base_q;
  logic             pair_q;
  logic [ESW_W-1:0] esz_q;
  logic [FSW_W-1:0] fsz_q;

  // Named internal events.
  logic load_begin, word_captured, load_complete, enough;

  logic [BUF_W-1:0] buf_bits;
  logic [CNT_W-1:0] wr_count;
  logic [POS_W-1:0] off_bits, r_pos;

  logic                 dl_sign, dl_exact, dr_sign, dr_exact;
  logic [ESS_MAX-1:0]   dl_exp_m1, dr_exp_m1;
  logic [EXP_MAX-1:0]   dl_exp, dr_exp;
  logic [FRAC_W-1:0]    dl_frac, dr_frac;
  logic [LEN_W-1:0]     dl_len, dr_len;
  logic [TOT_W-1:0]     l_bits_w, r_bits_w;

  int f_bits, o_bits, h_bits, lt_bits, rt_bits, need_bits, total_bits;

  assign busy          = (state != ST_IDLE);
  assign mem_req       = (state == ST_REQ);
  assign load_begin    = (state == ST_IDLE) && start;
  assign word_captured = (state == ST_WAIT) && mem_rvalid;
  assign load_complete = (state == ST_EVAL) && enough;

  assign mem_addr = {base_q[AW-1:BO_W], {BO_W{1'b0}}} + (AW'(wr_count) << BO_W);
  assign off_bits = POS_W'({base_q[BO_W-1:0], 3'b000});
  assign r_pos    = off_bits + POS_W'(l_bits_w);

  unum_word_buffer #(
    .WORD_W(CHUNK_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
  ) i_buf (
    .clk(clk), .rst_n(rst_n), .clear(load_begin), .wr_en(word_captured),
    .wr_data(mem_rdata), .buf_bits(buf_bits), .count(wr_count)
  );

  unum_ep_decode #(
    .ESS_MAX(ESS_MAX), .FSS_MAX(FSS_MAX), .CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS),
    .BUF_W(BUF_W), .POS_W(POS_W), .ESW_W(ESW_W), .FSW_W(FSW_W), .TOT_W(TOT_W)
  ) i_dec_l (
    .buf_bits(buf_bits), .pos(off_bits), .esz_w(esz_q), .fsz_w(fsz_q),
    .sign(dl_sign), .exact(dl_exact), .exp_m1(dl_exp_m1), .exp_val(dl_exp),
    .frac(dl_frac), .len(dl_len), .bits(l_bits_w)
  );

  unum_ep_decode #(
    .ESS_MAX(ESS_MAX), .FSS_MAX(FSS_MAX), .CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS),
    .BUF_W(BUF_W), .POS_W(POS_W), .ESW_W(ESW_W), .FSW_W(FSW_W), .TOT_W(TOT_W)
  ) i_dec_r (
    .buf_bits(buf_bits), .pos(r_pos), .esz_w(esz_q), .fsz_w(fsz_q),
    .sign(dr_sign), .exact(dr_exact), .exp_m1(dr_exp_m1), .exp_val(dr_exp),
    .frac(dr_frac), .len(dr_len), .bits(r_bits_w)
  );

  // Decide from the bits already held whether the element is complete.
  // Each size is trusted only once the header that carries it is present.
  always_comb begin
    f_bits  = int'(wr_count) * CHUNK_W;
    o_bits  = int'(off_bits);
    h_bits  = 2 + int'(esz_q) + int'(fsz_q);
    lt_bits = int'(l_bits_w);
    rt_bits = int'(r_bits_w);
    need_bits = o_bits + h_bits;
    if (f_bits >= need_bits)           need_bits = o_bits + lt_bits;
    if (f_bits >= need_bits && pair_q) need_bits = o_bits + lt_bits + h_bits;
    if (f_bits >= need_bits && pair_q) need_bits = o_bits + lt_bits + rt_bits;
    enough     = (f_bits >= need_bits) || (int'(wr_count) >= MAX_WORDS);
    total_bits = lt_bits + (pair_q ? rt_bits : 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      base_q <= '0;
      pair_q <= 1'b0;
      esz_q  <= '0;
      fsz_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          base_q <= start_addr;
          pair_q <= pair_mode;
          esz_q  <= cfg_esz_w;
          fsz_q  <= cfg_fsz_w;
          state  <= ST_REQ;
        end
        ST_REQ:  state <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) state <= ST_EVAL;
        ST_EVAL: begin
          if (enough) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_addr <= '0;
      l_sign <= 1'b0; l_exact <= 1'b0; l_exp_m1 <= '0; l_exp <= '0;
      l_frac <= '0;   l_len <= '0;
      r_sign <= 1'b0; r_exact <= 1'b0; r_exp_m1 <= '0; r_exp <= '0;
      r_frac <= '0;   r_len <= '0;
    end else if (load_complete) begin
      next_addr <= base_q + AW'((total_bits + 7) / 8);
      l_sign    <= dl_sign;
      l_exact   <= dl_exact;
      l_exp_m1  <= dl_exp_m1;
      l_exp     <= dl_exp;
      l_frac    <= dl_frac;
      l_len     <= dl_len;
      r_sign    <= pair_q ? dr_sign   : dl_sign;
      r_exact   <= pair_q ? dr_exact  : dl_exact;
      r_exp_m1  <= pair_q ? dr_exp_m1 : dl_exp_m1;
      r_exp     <= pair_q ? dr_exp    : dl_exp;
      r_frac    <= pair_q ? dr_frac   : dl_frac;
      r_len     <= pair_q ? dr_len    : dl_len;
    end
  end

endmodule

// File: rtl/unum_load_unpack_chk.sv
module unum_load_unpack_chk #(
  parameter int AW      = 32,
  parameter int ESW_W   = 3,
  parameter int FSW_W   = 4,
  parameter int ESS_MAX = 4,
  parameter int EXP_MAX = 16,
  parameter int FRAC_W  = 512,
  parameter int LEN_W   = 4,
  parameter int CHUNKS  = 8,
  parameter int CHUNK_W = 64,
  parameter int BO_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               mem_req,
  input logic [BO_W-1:0]    mem_addr_lo,
  input logic [AW-1:0]      next_addr,
  input logic               pair_q,
  input logic [ESW_W-1:0]   esz_q,
  input logic [FSW_W-1:0]   fsz_q,
  input logic               l_sign,
  input logic               l_exact,
  input logic [ESS_MAX-1:0] l_exp_m1,
  input logic [EXP_MAX-1:0] l_exp,
  input logic [FRAC_W-1:0]  l_frac,
  input logic [LEN_W-1:0]   l_len,
  input logic               r_sign,
  input logic               r_exact,
  input logic [ESS_MAX-1:0] r_exp_m1,
  input logic [EXP_MAX-1:0] r_exp,
  input logic [FRAC_W-1:0]  r_frac,
  input logic [LEN_W-1:0]   r_len
);

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r2_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr_lo == '0));

  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(next_addr) && $stable(l_frac) && $stable(r_frac)));

  a_r10_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pair_q) && $stable(esz_q) && $stable(fsz_q)));

  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (l_len != '0 && int'(l_len) <= CHUNKS && r_len != '0 && int'(r_len) <= CHUNKS));

  a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((l_frac << (int'(l_len) * CHUNK_W)) == '0 &&
              (r_frac << (int'(r_len) * CHUNK_W)) == '0));

  a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pair_q) |-> (r_sign == l_sign && r_exact == l_exact && r_exp_m1 == l_exp_m1 &&
                           r_exp == l_exp && r_frac == l_frac && r_len == l_len));

endmodule

bind unum_load_unpack unum_load_unpack_chk #(
  .AW(AW), .ESW_W(ESW_W), .FSW_W(FSW_W), .ESS_MAX(ESS_MAX), .EXP_MAX(EXP_MAX),
  .FRAC_W(FRAC_W), .LEN_W(LEN_W), .CHUNKS(CHUNKS), .CHUNK_W(CHUNK_W), .BO_W(BO_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_addr_lo(mem_addr[BO_W-1:0]), .next_addr(next_addr), .pair_q(pair_q),
  .esz_q(esz_q), .fsz_q(fsz_q),
  .l_sign(l_sign), .l_exact(l_exact), .l_exp_m1(l_exp_m1), .l_exp(l_exp),
  .l_frac(l_frac), .l_len(l_len),
  .r_sign(r_sign), .r_exact(r_exact), .r_exp_m1(r_exp_m1), .r_exp(r_exp),
  .r_frac(r_frac), .r_len(r_len)
);

// File: tb/test_unum_load_unpack.sv
`timescale 1ns/1ps
module test_unum_load_unpack;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic pair_mode = 1'b0;
  logic [2:0] cfg_esz_w = 3'd1;
  logic [3:0] cfg_fsz_w = 4'd1;
  logic busy, done, mem_req;
  logic [AW-1:0] mem_addr, next_addr;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic l_sign, l_exact, r_sign, r_exact;
  logic [3:0] l_exp_m1, r_exp_m1, l_len, r_len;
  logic [15:0] l_exp, r_exp;
  logic [511:0] l_frac, r_frac;

  always #2.5 clk = ~clk;

  unum_load_unpack i_unum_load_unpack (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .pair_mode(pair_mode), .cfg_esz_w(cfg_esz_w), .cfg_fsz_w(cfg_fsz_w),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .next_addr(next_addr),
    .l_sign(l_sign), .l_exact(l_exact), .l_exp_m1(l_exp_m1), .l_exp(l_exp),
    .l_frac(l_frac), .l_len(l_len),
    .r_sign(r_sign), .r_exact(r_exact), .r_exp_m1(r_exp_m1), .r_exp(r_exp),
    .r_frac(r_frac), .r_len(r_len)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  mem_b [256];
  logic [31:0] seed = 32'h1234_5678;
  int mem_lat = 1;
  int req_cnt = 0;
  logic [AW-1:0] exp_base = '0;

  // Expected endpoint values, index 0 = left, 1 = right.
  logic         e_sign [2];
  logic         e_exact [2];
  logic [3:0]   e_em1 [2];
  logic [15:0]  e_exp [2];
  logic [511:0] e_frac [2];
  int           e_len [2];

  logic [1023:0] ebits;
  int            epos;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic rnd(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic put(input logic [255:0] v, input int w);
    for (int i = 0; i < w; i++) begin
      ebits[epos] = v[i];
      epos++;
    end
  endtask

  // Memory model: one word returned mem_lat cycles after each request.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [AW-1:0] a;
        a = mem_addr;
        chk(a == exp_base + AW'(8 * req_cnt), "R2", "request address", 512'(a),
            512'(exp_base + AW'(8 * req_cnt)));
        req_cnt++;
        repeat (mem_lat) @(negedge clk);
        for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem_b[8'(a) + 8'(k)];
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic make_ep(input int side, input int ess_w, input int fss_w, input bit maxsz);
    logic [31:0] r;
    logic [255:0] fr;
    logic [255:0] ev;
    int em1, fm1, es, fs;
    rnd(r);
    em1 = maxsz ? (1 << ess_w) - 1 : int'(r[7:0]) % (1 << ess_w);
    fm1 = maxsz ? (1 << fss_w) - 1 : int'(r[23:8]) % (1 << fss_w);
    es = em1 + 1;
    fs = fm1 + 1;
    rnd(r);
    ev = '0;
    for (int i = 0; i < es; i++) ev[i] = r[i];
    fr = '0;
    for (int k = 0; k < 8; k++) begin
      rnd(r);
      for (int i = 0; i < 32; i++) if (32*k + i < fs) fr[32*k + i] = r[i];
    end
    rnd(r);
    e_sign[side]  = r[0];
    e_exact[side] = r[1];
    e_em1[side]   = 4'(em1);
    e_exp[side]   = ev[15:0];
    e_frac[side]  = '0;
    for (int i = 0; i < fs; i++) e_frac[side][511 - i] = fr[fs - 1 - i];
    e_len[side]   = (fs + 63) / 64;
    put(256'(r[0]), 1);
    put(256'(r[1]), 1);
    put(256'(em1), ess_w);
    put(256'(fm1), fss_w);
    put(ev, es);
    put(fr, fs);
  endtask

  task automatic check_ep(input int side, input string req);
    logic s, x;
    logic [3:0] m1, ln;
    logic [15:0] ex;
    logic [511:0] fr;
    if (side == 0) begin s = l_sign; x = l_exact; m1 = l_exp_m1; ex = l_exp; fr = l_frac; ln = l_len; end
    else begin s = r_sign; x = r_exact; m1 = r_exp_m1; ex = r_exp; fr = r_frac; ln = r_len; end
    chk(s == e_sign[side], req, "sign", 512'(s), 512'(e_sign[side]));
    chk(x == e_exact[side], req, "exact", 512'(x), 512'(e_exact[side]));
    chk(m1 == e_em1[side], req, "exp_m1 (R4)", 512'(m1), 512'(e_em1[side]));
    chk(ex == e_exp[side], req, "exponent (R4)", 512'(ex), 512'(e_exp[side]));
    chk(fr == e_frac[side], req, "fraction (R5)", fr, e_frac[side]);
    chk(int'(ln) == e_len[side], req, "len (R5)", 512'(ln), 512'(e_len[side]));
  endtask

  task automatic run_load(input int ess_w, input int fss_w, input int off,
                          input bit pair, input bit maxsz, input bit disturb);
    logic [31:0] r;
    logic [AW-1:0] a;
    int total, nbytes, words, cyc;
    logic [511:0] keep_frac;
    ebits = '0;
    epos = 0;
    make_ep(0, ess_w, fss_w, maxsz);
    if (pair) make_ep(1, ess_w, fss_w, maxsz);
    else begin
      e_sign[1] = e_sign[0]; e_exact[1] = e_exact[0]; e_em1[1] = e_em1[0];
      e_exp[1] = e_exp[0]; e_frac[1] = e_frac[0]; e_len[1] = e_len[0];
    end
    total  = epos;
    nbytes = (total + 7) / 8;
    words  = (8 * off + total + 63) / 64;
    rnd(r);
    for (int i = 0; i < 8; i++) ebits[total + i] = r[i];
    for (int b = 0; b < 256; b++) begin
      rnd(r);
      mem_b[b] = r[7:0];
    end
    a = AW'(16 + off);
    for (int b = 0; b < nbytes; b++) mem_b[16 + off + b] = ebits[8*b +: 8];
    exp_base = a & ~AW'(7);
    req_cnt = 0;

    start = 1'b1; start_addr = a; pair_mode = pair;
    cfg_esz_w = 3'(ess_w); cfg_fsz_w = 4'(fss_w);
    @(negedge clk);
    if (disturb) begin
      // R10: start, mode and widths change while busy; the load must ignore them.
      start_addr = a + AW'(40); pair_mode = ~pair;
      cfg_esz_w = 3'(ess_w % 4 + 1); cfg_fsz_w = 4'(fss_w % 8 + 1);
      @(negedge clk);
    end
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      chk(1'b0, "R11", "done timeout", '0, 512'(1));
      return;
    end
    chk(!busy, "R11", "busy low with done", 512'(busy), '0);
    chk(next_addr == a + AW'(nbytes), "R9", "next_addr", 512'(next_addr), 512'(a + AW'(nbytes)));
    chk(req_cnt == words, "R8", "word count", 512'(req_cnt), 512'(words));
    check_ep(0, disturb ? "R3/R10" : "R3");
    check_ep(1, pair ? "R6" : "R7");
    if (disturb) begin
      keep_frac = l_frac;
      @(negedge clk);
      chk(!done, "R11", "done pulse width", 512'(done), '0);
      @(negedge clk);
      chk(next_addr == a + AW'(nbytes) && l_frac == keep_frac, "R11", "result hold",
          512'(next_addr), 512'(a + AW'(nbytes)));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int iter;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "reset outputs",
        512'({busy, done, mem_req}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "idle after reset",
        512'({busy, done, mem_req}), '0);
    iter = 0;
    for (int ew = 1; ew <= 4; ew++)
      for (int fw = 1; fw <= 8; fw++)
        for (int off = 0; off < 8; off++)
          for (int pm = 0; pm < 2; pm++)
            for (int mx = 0; mx < 2; mx++) begin
              mem_lat = 1 + iter % 3;
              run_load(ew, fw, off, pm[0], mx[0], (iter % 4) == 1);
              iter++;
            end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule